// File: doc/BRIEF.md
# Character Row Pixel Generator with High-Bit Attribute

This block turns a stream of character codes into the serial pixel stream of a character-mode display. For each character cell the video timing presents a code and the current scan row, then pulses a load strobe. The block looks up one horizontal slice of the character's glyph and shifts it out, one pixel for each pixel-enable pulse. Glyphs are 8 pixels wide and 8 rows tall. The glyph address is the low seven code bits followed by the 3-bit row index.

The top bit of the code is an attribute, and a static configuration input decides what it means. In reverse mode a high-bit character is drawn from the fixed glyph set with every pixel inverted. In custom mode a high-bit character is drawn from a writable glyph RAM. A host loads that RAM through a simple write port, before or during display. Codes with the top bit clear always use the fixed glyph set.

The fixed glyph set is a constant store computed in the RTL. Its contents are a generated stand-in pattern that a real font function can replace. The video timing itself is outside this block.

Top module: `chargen_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `pixel` is 0.
- R2: With `code[7]`=0, the row shifted out is the fixed glyph row for address A = {code[6:0], row}. That row equals (A mod 256) XOR 0x5A.
- R3: Row bit 7 (MSB) appears on `pixel` after the second rising edge counted from the edge that samples `load`. Each later `pix_en` edge then presents the next lower bit.
- R4: With `code[7]`=1 and `hi_custom`=0 (reverse mode), the row shifted out is the bitwise inverse of the fixed glyph row for {code[6:0], row}.
- R5: With `code[7]`=1 and `hi_custom`=1 (custom mode), the row shifted out is the glyph RAM word at address {code[6:0], row}, not inverted.
- R6: A clock edge with `wr_en`=1 stores `wr_data` at `wr_addr` in the glyph RAM (1024 words of 8 bits).
- R7: If a write hits the address being read on the same load edge, that load returns the old RAM word. The new word is returned on later loads.
- R8: The shifter moves only on `pix_en` edges and fills with 0. After eight shifts `pixel` is 0. With `pix_en` low, `pixel` holds.
- R9: `code[7]` and `hi_custom` are captured on the load edge. Changing `hi_custom` afterwards does not alter the row in flight. A shifter reload takes priority over a `pix_en` shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Character boundary strobe; samples code and row |
| code | input | 8 | Character code; bit 7 is the attribute |
| row | input | 3 | Scan row inside the glyph |
| hi_custom | input | 1 | 0: bit 7 means reverse video; 1: bit 7 selects glyph RAM |
| pix_en | input | 1 | Pixel enable; shifts the row one pixel |
| wr_en | input | 1 | Glyph RAM write enable |
| wr_addr | input | 10 | Glyph RAM write address {code[6:0], row} |
| wr_data | input | 8 | Glyph RAM write data, MSB is the leftmost pixel |
| pixel | output | 1 | Registered serial pixel |

## Verification
The assertions assume that `load` and `pix_en` are never unknown once reset has been released. They also assume that a write address is never unknown while `wr_en` is high. The bench meets these assumptions by driving every control input to a defined level from time zero and by changing inputs only on falling edges.

The sweep covers every code in both modes and on every row. It toggles `hi_custom` right after each load and holds `pix_en` high across the reload cycle on alternate rows. Both variations stay inside the assumed protocol while stressing the capture and priority rules.

// File: rtl/chargen_pkg.sv
package chargen_pkg;

  typedef enum logic {
    HI_REVERSE = 1'b0,
    HI_CUSTOM  = 1'b1
  } hi_mode_e;

  // Generated stand-in font: glyph-row index XOR a fixed mask.
  function automatic logic [31:0] fixed_pattern(input logic [31:0] idx);
    return idx ^ 32'h0000_005A;
  endfunction

endpackage

// File: rtl/chargen_rom.sv
module chargen_rom #(
  parameter int AW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [GW-1:0] rd_q
);

  // Constant store, registered read so it maps to block ROM.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= GW'(chargen_pkg::fixed_pattern(32'(rd_addr)));
  end

endmodule

// File: rtl/chargen_ram.sv
module chargen_ram #(
  parameter int AW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [GW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [GW-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [GW-1:0] mem [DEPTH];

  // Single clocked process: a read of the address being written sees old data.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // R6: write address must be defined when writing.
  p_wr_addr_known_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$isunknown(wr_addr));

endmodule

// File: rtl/chargen_shifter.sv
module chargen_shifter #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          pix_en,
  input  logic [GW-1:0] din,
  output logic          pixel
);

  logic [GW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)         shreg <= '0;
    else if (load)   shreg <= din;
    else if (pix_en) shreg <= {shreg[GW-2:0], 1'b0};
  end

  assign pixel = shreg[GW-1];

  // R1: reset clears the output.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pixel == 1'b0));

  // R8: idle pixel enable holds the row.
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !pix_en) |=> $stable(shreg));

  // R8: a shift moves one place and fills with zero.
  p_shift_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && pix_en) |=> (shreg[0] == 1'b0) && (pixel == $past(shreg[GW-2])));

  // R9: reload wins over a shift.
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (shreg == $past(din)));

endmodule

// File: rtl/chargen_top.sv
module chargen_top #(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3,
  parameter int GW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [CODE_W-1:0]         code,
  input  logic [ROW_W-1:0]          row,
  input  logic                      hi_custom,
  input  logic                      pix_en,
  input  logic                      wr_en,
  input  logic [CODE_W-1+ROW_W-1:0] wr_addr,
  input  logic [GW-1:0]             wr_data,
  output logic                      pixel
);

  import chargen_pkg::*;

  localparam int AW = CODE_W - 1 + ROW_W;

  logic [AW-1:0] glyph_addr;
  logic [GW-1:0] rom_q, ram_q, glyph_sel;
  logic          hi_q, vld_q;
  hi_mode_e      mode_q;

  assign glyph_addr = {code[CODE_W-2:0], row};

  // Stage 1: glyph fetch, attribute and mode captured with the load.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      hi_q   <= 1'b0;
      mode_q <= HI_REVERSE;
    end else begin
      vld_q <= load;
      if (load) begin
        hi_q   <= code[CODE_W-1];
        mode_q <= hi_mode_e'(hi_custom);
      end
    end
  end

  chargen_rom #(.AW(AW), .GW(GW)) u_rom (
    .clk     (clk),
    .rd_en   (load),
    .rd_addr (glyph_addr),
    .rd_q    (rom_q)
  );

  chargen_ram #(.AW(AW), .GW(GW)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (load),
    .rd_addr (glyph_addr),
    .rd_q    (ram_q)
  );

  // Attribute treatment: plain, inverted (reverse video) or RAM bank.
  always_comb begin
    if (!hi_q)                  glyph_sel = rom_q;
    else if (mode_q == HI_CUSTOM) glyph_sel = ram_q;
    else                        glyph_sel = ~rom_q;
  end

  chargen_shifter #(.GW(GW)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (vld_q),
    .pix_en (pix_en),
    .din    (glyph_sel),
    .pixel  (pixel)
  );

  // R3: a load strobe produces a shifter reload one edge later.
  p_load_to_reload_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> vld_q);

  // R3: after the reload the output shows the selected row's MSB.
  p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> (pixel == $past(glyph_sel[GW-1])));

  // R9: control inputs are defined outside reset.
  p_ctrl_known_r9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({load, pix_en}));

endmodule

// File: tb/tb_chargen_top.sv
`timescale 1ns/1ps
module tb_chargen_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] code = '0;
  logic [2:0] row = '0;
  logic       hi_custom = 1'b0;
  logic       pix_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pixel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] ram_m [1024];

  always #2.5 clk = ~clk;

  chargen_top dut (
    .clk(clk), .rst(rst), .load(load), .code(code), .row(row),
    .hi_custom(hi_custom), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pixel(pixel)
  );

  function automatic logic [7:0] rom_ref(input logic [9:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Load one glyph row and collect its 8 pixels (R3 timing).
  task automatic run_row(input logic [7:0] c, input logic [2:0] r, input logic m,
                         input logic pe_hold, output logic [7:0] got);
    @(negedge clk);
    code = c; row = r; hi_custom = m; load = 1'b1; pix_en = pe_hold;
    @(negedge clk);
    load = 1'b0;
    hi_custom = ~m;   // R9: late change must not matter
    @(negedge clk);
    got[7] = pixel;
    pix_en = 1'b1;
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      got[i] = pixel;
    end
    pix_en = 1'b0;
  endtask

  initial begin
    logic [7:0] got, exp, old;
    logic [9:0] a;
    repeat (3) @(negedge clk);
    chk("R1 reset", {7'd0, pixel}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {7'd0, pixel}, 8'd0);

    // R6: fill the glyph RAM.
    for (int k = 0; k < 1024; k++) begin
      wr_en = 1'b1; wr_addr = 10'(k); wr_data = 8'((k * 37 + 11) & 255);
      ram_m[k] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;

    // Sweep: both modes, every code, every row.
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 256; c++) begin
        for (int r = 0; r < 8; r++) begin
          a = {7'(c), 3'(r)};
          run_row(8'(c), 3'(r), 1'(m), 1'(r & 1), got);
          if (c < 128)       begin exp = rom_ref(a);  chk("R2 fixed glyph", got, exp); end
          else if (m == 0)   begin exp = ~rom_ref(a); chk("R4 reverse", got, exp); end
          else               begin exp = ram_m[a];    chk("R5 custom RAM", got, exp); end
        end
      end
    end

    // R8: zero fill after eight shifts, and hold while pix_en is low.
    run_row(8'h80, 3'd0, 1'b0, 1'b0, got);   // ~0x5A = A5, LSB 1
    chk("R8 last bit", {7'd0, got[0]}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R8 hold", {7'd0, pixel}, 8'd1);
    pix_en = 1'b1; @(negedge clk); pix_en = 1'b0;
    chk("R8 zero fill", {7'd0, pixel}, 8'd0);

    // R7: write and load of the same address in one cycle.
    a = {7'h15, 3'd4};
    old = ram_m[a];
    @(negedge clk);
    code = 8'h95; row = 3'd4; hi_custom = 1'b1; load = 1'b1;
    wr_en = 1'b1; wr_addr = a; wr_data = ~old;
    @(negedge clk);
    load = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    got[7] = pixel; pix_en = 1'b1;
    for (int i = 6; i >= 0; i--) begin @(negedge clk); got[i] = pixel; end
    pix_en = 1'b0;
    chk("R7 old data", got, old);
    ram_m[a] = ~old;
    run_row(8'h95, 3'd4, 1'b1, 1'b0, got);
    chk("R7 new data", got, ~old);
    // R9: mode is captured at load (late toggle inside run_row).
    run_row(8'h95, 3'd4, 1'b0, 1'b1, got);
    chk("R9 captured mode", got, ~rom_ref(a));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule